// File: doc/BRIEF.md
# Burst Word Address Sequencer

This block produces the word address for each beat of a four-beat burst into a synchronous memory. When the load/advance strobe is low and every chip select is active, it takes in an external word address. Each later cycle with the strobe high steps a two-bit beat counter. The output address keeps the captured upper bits. Its two lowest bits come from the captured start offset combined with the beat count, in one of two orders that a run-time order pin selects.

In linear order the low bits are a wrapping increment of the start offset. In interleaved order they are the start offset XOR the beat count. The order pin is treated as static and feeds the output through combinational logic only. A suspend input freezes all state. A load cycle with any chip select inactive ends the burst in progress. Storage and the data path belong to the surrounding memory.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_ni is low and just after it rises, active_o is 0, beat_o is 0 and addr_o is all zeros.
- R2: A clock edge with suspend_i=0, load_ni=0 and every bit of sel_i equal to 1 captures addr_i. After that edge active_o=1, beat_o=0 and addr_o equals addr_i in either order.
- R3: A clock edge with suspend_i=0, load_ni=1 and active_o=1 raises beat_o by one modulo 4.
- R4: With order_i=0 (linear), addr_o[1:0] equals (start + beat_o) mod 4, where start is the captured addr_i[1:0].
- R5: With order_i=1 (interleaved), addr_o[1:0] equals start XOR beat_o. A change of order_i reaches addr_o with no clock edge.
- R6: addr_o[ADDR_W-1:2] stays at the captured value for the whole burst. Advancing from beat 3 returns to beat 0 of the same four-word block with no carry into the upper bits.
- R7: While suspend_i=1, a clock edge changes none of active_o, beat_o or the captured address, whatever load_ni, sel_i and addr_i carry.
- R8: A clock edge with suspend_i=0, load_ni=0 and any bit of sel_i equal to 0 clears active_o. beat_o and addr_o keep their values.
- R9: A clock edge with suspend_i=0, load_ni=1 and active_o=0 changes neither beat_o nor addr_o, and active_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| suspend_i | input | 1 | High freezes all state for the cycle |
| load_ni | input | 1 | Low: load a new address; high: advance the burst |
| sel_i | input | NUM_SEL | Chip selects, all must be 1 for a load to start a burst |
| addr_i | input | ADDR_W | External word address captured on load |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| addr_o | output | ADDR_W | Current burst word address |
| active_o | output | 1 | A burst is in progress |
| beat_o | output | 2 | Beat index within the burst |

## Verification
Load, advance, suspend and deselect all take effect on the first rising edge after their inputs are applied. The bench therefore drives each cycle's inputs 2 ns after a rising edge and reads the outputs 2 ns after the next one, once the registered state has settled. A change of order_i alters addr_o with no clock edge, so it is checked 1 ns after the pin toggles, between edges. Each burst scenario reads every beat of a full wrap, so the expected offset sequence is compared beat by beat for all four start offsets in both orders.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  localparam int unsigned OFS_W = 2;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;

  typedef logic [OFS_W-1:0] ofs_t;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_addr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  input  logic step_i,
  output ofs_t beat_o
);
  ofs_t cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (en_i && clr_i)      cnt_q <= '0;
    else if (en_i && step_i)     cnt_q <= cnt_q + ofs_t'(1);
  end

  assign beat_o = cnt_q;

  // wrap within the block: 3 -> 0
  assert_step_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && step_i && !clr_i) |=> (cnt_q == ofs_t'($past(cnt_q) + ofs_t'(1))));

  assert_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && clr_i) |=> (cnt_q == '0));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_addr_pkg::*;
(
  input  ofs_t         start_i,
  input  ofs_t         beat_i,
  input  burst_order_e order_i,
  output ofs_t         ofs_o
);
  ofs_t lin_ofs;
  ofs_t ilv_ofs;

  assign lin_ofs = start_i + beat_i;
  assign ilv_ofs = start_i ^ beat_i;

  always_comb begin
    unique case (order_i)
      ORD_INTERLEAVE: ofs_o = ilv_ofs;
      default:        ofs_o = lin_ofs;
    endcase
  end

  // both orders begin at the start offset
  always_comb begin
    if (beat_i == '0) assert_first_beat_R4: assert (ofs_o == start_i);
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned NUM_SEL = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              suspend_i,
  input  logic              load_ni,
  input  logic [NUM_SEL-1:0] sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              order_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              active_o,
  output logic [1:0]        beat_o
);
  localparam int unsigned UP_W = ADDR_W - OFS_W;

  logic            selected;
  logic            run;
  logic            take;
  logic            stop;
  logic            step;
  logic [UP_W-1:0] upper_q;
  ofs_t            start_q;
  logic            active_q;
  ofs_t            beat;
  ofs_t            ofs;

  assign selected = &sel_i;
  assign run      = !suspend_i;
  assign take     = run && !load_ni && selected;
  assign stop     = run && !load_ni && !selected;
  assign step     = load_ni && active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upper_q  <= '0;
      start_q  <= '0;
      active_q <= 1'b0;
    end else if (take) begin
      upper_q  <= addr_i[ADDR_W-1:OFS_W];
      start_q  <= addr_i[OFS_W-1:0];
      active_q <= 1'b1;
    end else if (stop) begin
      active_q <= 1'b0;
    end
  end

  burst_beat_ctr u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (run),
    .clr_i  (take),
    .step_i (step),
    .beat_o (beat)
  );

  burst_order_map u_map (
    .start_i (start_q),
    .beat_i  (beat),
    .order_i (burst_order_e'(order_i)),
    .ofs_o   (ofs)
  );

  assign addr_o   = {upper_q, ofs};
  assign active_o = active_q;
  assign beat_o   = beat;

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> (active_o && beat_o == 2'd0 && addr_o == $past(addr_i)));

  assert_upper_fixed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && step) |=> $stable(addr_o[ADDR_W-1:OFS_W]));

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_i |=> ($stable(active_o) && $stable(beat_o) && $stable(upper_q) && $stable(start_q)));

  assert_stop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop |=> (!active_o && $stable(beat_o) && $stable(upper_q)));

  assert_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && load_ni && !active_o) |=> (!active_o && $stable(beat_o) && $stable(upper_q)));
endmodule

// File: tb/burst_addr_gen_tb_top.sv
`timescale 1ns/1ps
module burst_addr_gen_tb_top;
  localparam int unsigned ADDR_W  = 20;
  localparam int unsigned NUM_SEL = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              suspend = 1'b0;
  logic              load_n = 1'b1;
  logic [NUM_SEL-1:0] sel = '1;
  logic [ADDR_W-1:0] addr = '0;
  logic              order = 1'b0;
  logic [ADDR_W-1:0] addr_o;
  logic              active_o;
  logic [1:0]        beat_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W), .NUM_SEL(NUM_SEL)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .suspend_i(suspend), .load_ni(load_n),
    .sel_i(sel), .addr_i(addr), .order_i(order),
    .addr_o(addr_o), .active_o(active_o), .beat_o(beat_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // apply inputs, let one rising edge pass, sample 2 ns later
  task automatic cyc(logic s, logic ln, logic [NUM_SEL-1:0] se, logic [ADDR_W-1:0] a);
    suspend = s; load_n = ln; sel = se; addr = a;
    @(posedge clk); #2;
  endtask

  function automatic logic [1:0] exp_ofs(logic [1:0] st, logic [1:0] k, logic ord);
    return ord ? (st ^ k) : 2'(st + k);
  endfunction

  task automatic test_reset();
    check("R1 active", 32'(active_o), 0);
    check("R1 beat", 32'(beat_o), 0);
    check("R1 addr", 32'(addr_o), 0);
  endtask

  task automatic test_burst(logic ord);
    logic [ADDR_W-1:0] base;
    order = ord;
    for (int s = 0; s < 4; s++) begin
      base = {18'h2AB3C, 2'(s)};
      cyc(0, 0, '1, base);
      check("R2 load active", 32'(active_o), 1);
      check("R2 load addr", 32'(addr_o), 32'(base));
      for (int k = 1; k < 6; k++) begin
        cyc(0, 1, '1, '0);
        check("R3 beat", 32'(beat_o), 32'(k % 4));
        check(ord ? "R5 interleaved ofs" : "R4 linear ofs", 32'(addr_o[1:0]),
              32'(exp_ofs(2'(s), 2'(k % 4), ord)));
        check("R6 upper fixed", 32'(addr_o[ADDR_W-1:2]), 32'(base[ADDR_W-1:2]));
      end
    end
  endtask

  task automatic test_stall(logic ord);
    order = ord;
    cyc(0, 0, '1, 20'h00013);
    cyc(0, 1, '1, '0);
    cyc(1, 0, '1, 20'hFFFF0);
    cyc(1, 1, '1, 20'h55555);
    check("R7 hold beat", 32'(beat_o), 1);
    check("R7 hold addr", 32'(addr_o), 32'({18'h00004, exp_ofs(2'd3, 2'd1, ord)}));
    check("R7 hold active", 32'(active_o), 1);
    cyc(0, 1, '1, '0);
    check("R7 resume beat", 32'(beat_o), 2);
    check("R7 resume addr", 32'(addr_o[1:0]), 32'(exp_ofs(2'd3, 2'd2, ord)));
  endtask

  task automatic test_deselect();
    logic [ADDR_W-1:0] held;
    order = 1'b0;
    cyc(0, 0, '1, 20'h0ABC1);
    cyc(0, 1, '1, '0);
    held = addr_o;
    for (int b = 0; b < NUM_SEL; b++) begin
      cyc(0, 0, ~(NUM_SEL'(1) << b), 20'h77777);
      check("R8 stop active", 32'(active_o), 0);
      check("R8 addr kept", 32'(addr_o), 32'(held));
    end
    cyc(0, 1, '1, '0);
    cyc(0, 1, '1, '0);
    check("R9 idle beat", 32'(beat_o), 1);
    check("R9 idle active", 32'(active_o), 0);
    check("R9 idle addr", 32'(addr_o), 32'(held));
  endtask

  task automatic test_order_switch();
    order = 1'b0;
    cyc(0, 0, '1, 20'h00401);
    cyc(0, 1, '1, '0);
    cyc(0, 1, '1, '0);
    check("R4 linear before switch", 32'(addr_o[1:0]), 3);
    order = 1'b1; #1;
    check("R5 async switch", 32'(addr_o[1:0]), 3);
    cyc(0, 1, '1, '0);
    check("R5 interleaved beat3", 32'(addr_o[1:0]), 2);
    order = 1'b0; #1;
    check("R5 async back to linear", 32'(addr_o[1:0]), 0);
  endtask

  initial begin
    #4000000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #15;
    test_reset();
    #20 rst_n = 1'b1;
    @(posedge clk); #2;
    test_reset();
    test_burst(1'b0);
    test_burst(1'b1);
    test_stall(1'b0);
    test_stall(1'b1);
    test_deselect();
    test_order_switch();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule